// File: doc/BRIEF.md
# Paged Outbound Address Translation Table

This block sits between a DMA master that issues 32-bit local addresses and a bus bridge that needs 64-bit host addresses. A window of the local address space is cut into equal pages whose size is a power of two. Each page owns one table entry. The entry holds only the host-side page address. The upper local bits pick the entry. The bits inside the page pass through untouched. Two adjacent local pages can therefore land on any two unrelated host pages, which lets host software place a buffer that is scattered across physical memory behind one contiguous local range.

Software fills the table at run time through a small word-wide register port that is separate from the request path. Each entry has a valid bit. A request that selects an invalid entry, or that lies outside the window, is accepted and then flagged with a one-cycle error pulse instead of producing an address.

The request path is a one-slot pipeline controlled by a three-state machine. ST_IDLE means the output slot is empty. ST_HOLD means a translated address is being presented. ST_FAULT means the error pulse is being shown. An accepted request with a hit moves the machine to ST_HOLD. An accepted request with a miss moves it to ST_FAULT. With no accepted request, ST_IDLE and ST_FAULT return to ST_IDLE, and so does ST_HOLD once the output is taken. ST_HOLD stays in ST_HOLD while the consumer stalls.

Top module: `addr_xlat_top`

## Requirements
- R1: After reset, every entry is invalid, `out_valid` and `xlat_err` are low, `req_ready` is high, and every register reads back as zero.
- R2: For a request in the window, the entry index is (req_addr - WIN_BASE) >> PAGE_BITS. `out_addr` is then entry bits [63:PAGE_BITS] joined with req_addr bits [PAGE_BITS-1:0].
- R3: Register word address 2k is the low word of entry k and holds entry bits [31:0]. Bit 0 of that word is the valid bit, bits [PAGE_BITS-1:1] are discarded on write and read as zero, and writing it sets the valid bit from data bit 0. Word address 2k+1 is the high word, entry bits [63:32], and writing it leaves the valid bit unchanged.
- R4: A `reg_rd` pulse at one clock edge presents the addressed word on `reg_rdata`, with `reg_rvalid` high, in the following cycle only.
- R5: A request that selects an entry whose valid bit is 0 is accepted. In the next cycle `xlat_err` is high for exactly one cycle and `out_valid` stays low.
- R6: A request below WIN_BASE, or at or above WIN_BASE + N_ENTRIES·2^PAGE_BITS, behaves as in R5.
- R7: A request accepted at a clock edge has its translated address, with `out_valid` high, in the very next cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_addr` holds its value and `req_ready` is low.
- R9: A request accepted at the same edge as a table write uses the old entry value. A request accepted later uses the new value. An address already being presented is not changed by the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request address is offered |
| req_ready | output | 1 | Request slot can accept |
| req_addr | input | 32 | Local address to translate |
| out_valid | output | 1 | Translated address is presented |
| out_ready | input | 1 | Consumer takes the translated address |
| out_addr | output | 64 | Translated host address |
| xlat_err | output | 1 | One-cycle pulse: the accepted request missed |
| reg_wr | input | 1 | Table register write strobe |
| reg_rd | input | 1 | Table register read strobe |
| reg_addr | input | $clog2(N_ENTRIES)+1 | Table register word address |
| reg_wdata | input | 32 | Table register write data |
| reg_rdata | output | 32 | Table register read data |
| reg_rvalid | output | 1 | Read data is valid |

## Verification
The properties assume that `rst_n` is held low across the first clock edge and that all inputs carry known values. They do not assume that `req_valid` is held or that `req_addr` is stable while a request waits, because the offset check compares against the address sampled at acceptance. The stimulus changes inputs only on the falling clock edge and keeps every address known. Random requests are spread across the window and a little beyond both of its ends, so that hits, invalid entries and out-of-window misses all occur while random register writes keep changing the table.

// File: rtl/addr_xlat_pkg.sv
package addr_xlat_pkg;
    localparam int HOST_W = 64;
    localparam int LOC_W  = 32;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FAULT = 2'd2
    } xlat_state_e;
endpackage

// File: rtl/addr_xlat_regs.sv
module addr_xlat_regs
    import addr_xlat_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int PAGE_BITS = 12,
    parameter int REG_AW    = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_wr,
    input  logic                               reg_rd,
    input  logic [REG_AW-1:0]                  reg_addr,
    input  logic [WORD_W-1:0]                  reg_wdata,
    output logic [WORD_W-1:0]                  reg_rdata,
    output logic                               reg_rvalid,
    output logic [N_ENTRIES-1:0][HOST_W-1:0]   tab_addr,
    output logic [N_ENTRIES-1:0]               tab_valid
);
    localparam int IDX_W = REG_AW - 1;
    localparam logic [HOST_W-1:0] OFS_MASK = (64'd1 << PAGE_BITS) - 64'd1;
    localparam logic [WORD_W-1:0] LOW_KEEP = ~OFS_MASK[WORD_W-1:0];

    logic [IDX_W-1:0]  sel_idx;
    logic              sel_hi;
    logic [WORD_W-1:0] rd_word;

    assign sel_idx = reg_addr[REG_AW-1:1];
    assign sel_hi  = reg_addr[0];

    for (genvar k = 0; k < N_ENTRIES; k++) begin : g_entry
        logic [HOST_W-1:0] ent_q;
        logic              ent_v;
        logic              wr_hit;

        assign wr_hit = reg_wr && (sel_idx == IDX_W'(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
                ent_v <= 1'b0;
            end else if (wr_hit) begin
                if (sel_hi) begin
                    ent_q[63:32] <= reg_wdata;
                end else begin
                    ent_q[31:0] <= reg_wdata & LOW_KEEP;
                    ent_v       <= reg_wdata[0];
                end
            end
        end

        assign tab_addr[k]  = ent_q;
        assign tab_valid[k] = ent_v;
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < N_ENTRIES; k++) begin
            if (sel_idx == IDX_W'(k)) begin
                rd_word = sel_hi ? tab_addr[k][63:32]
                                 : (tab_addr[k][31:0] | {31'd0, tab_valid[k]});
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) begin
                reg_rdata <= rd_word;
            end
        end
    end
endmodule

// File: rtl/addr_xlat_lookup.sv
module addr_xlat_lookup
    import addr_xlat_pkg::*;
#(
    parameter int          N_ENTRIES = 8,
    parameter int          PAGE_BITS = 12,
    parameter logic [31:0] WIN_BASE  = 32'h4000_0000,
    parameter int          IDX_W     = 3
) (
    input  logic [LOC_W-1:0]                   laddr,
    input  logic [N_ENTRIES-1:0][HOST_W-1:0]   tab_addr,
    input  logic [N_ENTRIES-1:0]               tab_valid,
    output logic                               hit,
    output logic [HOST_W-1:0]                  host
);
    localparam logic [HOST_W-1:0] OFS_MASK = (64'd1 << PAGE_BITS) - 64'd1;

    logic [LOC_W:0]   rel;
    logic [LOC_W-1:0] page_no;
    logic [IDX_W-1:0] idx;
    logic             in_win;

    always_comb begin
        rel     = {1'b0, laddr} - {1'b0, WIN_BASE};
        page_no = rel[LOC_W-1:0] >> PAGE_BITS;
        in_win  = !rel[LOC_W] && (page_no < 32'(N_ENTRIES));
        idx     = page_no[IDX_W-1:0];
        hit     = in_win && tab_valid[idx];
        host    = (tab_addr[idx] & ~OFS_MASK) | ({32'd0, laddr} & OFS_MASK);
    end
endmodule

// File: rtl/addr_xlat_ctrl.sv
module addr_xlat_ctrl
    import addr_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              lk_hit,
    input  logic [HOST_W-1:0] lk_host,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [HOST_W-1:0] out_addr,
    output logic              xlat_err
);
    xlat_state_e       state_q, state_d;
    logic [HOST_W-1:0] addr_q;
    logic              take;

    assign take = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FAULT: begin
                if (take) state_d = lk_hit ? ST_HOLD : ST_FAULT;
                else      state_d = ST_IDLE;
            end
            ST_HOLD: begin
                if (!out_ready) state_d = ST_HOLD;
                else if (take)  state_d = lk_hit ? ST_HOLD : ST_FAULT;
                else            state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take && lk_hit) addr_q <= lk_host;
        end
    end

    always_comb begin
        req_ready = (state_q != ST_HOLD) || out_ready;
        out_valid = (state_q == ST_HOLD);
        xlat_err  = (state_q == ST_FAULT);
        out_addr  = addr_q;
    end
endmodule

// File: rtl/addr_xlat_top.sv
module addr_xlat_top
    import addr_xlat_pkg::*;
#(
    parameter int          N_ENTRIES = 8,
    parameter int          PAGE_BITS = 12,
    parameter logic [31:0] WIN_BASE  = 32'h4000_0000,
    localparam int         IDX_W     = $clog2(N_ENTRIES),
    localparam int         REG_AW    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [63:0]       out_addr,
    output logic              xlat_err,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid
);
    logic [N_ENTRIES-1:0][HOST_W-1:0] tab_addr;
    logic [N_ENTRIES-1:0]             tab_valid;
    logic                             lk_hit;
    logic [HOST_W-1:0]                lk_host;

    addr_xlat_regs #(
        .N_ENTRIES(N_ENTRIES), .PAGE_BITS(PAGE_BITS), .REG_AW(REG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .tab_addr(tab_addr), .tab_valid(tab_valid)
    );

    addr_xlat_lookup #(
        .N_ENTRIES(N_ENTRIES), .PAGE_BITS(PAGE_BITS),
        .WIN_BASE(WIN_BASE), .IDX_W(IDX_W)
    ) u_lookup (
        .laddr(req_addr), .tab_addr(tab_addr), .tab_valid(tab_valid),
        .hit(lk_hit), .host(lk_host)
    );

    addr_xlat_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .lk_hit(lk_hit), .lk_host(lk_host),
        .out_ready(out_ready), .out_valid(out_valid),
        .out_addr(out_addr), .xlat_err(xlat_err)
    );
endmodule

// File: rtl/addr_xlat_chk.sv
module addr_xlat_chk #(
    parameter int PAGE_BITS = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_addr,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_addr,
    input logic        xlat_err,
    input logic        reg_rd,
    input logic        reg_rvalid
);
    // R7: an accepted request yields a result in the next cycle
    p_result_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (out_valid || xlat_err));

    // R8: a stalled output keeps its address
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

    // R8: no new request is taken while the output stalls
    p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !req_ready);

    // R5: an error pulse is caused by a request accepted one cycle before
    p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_err |-> $past(req_valid && req_ready));

    // R5: an error never comes with a translated address
    p_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_err |-> !out_valid);

    // R2: the in-page offset passes through unchanged
    p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            (xlat_err || out_addr[PAGE_BITS-1:0] == $past(req_addr[PAGE_BITS-1:0])));

    // R4: read data follows a read strobe by one cycle, and only then
    p_read_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
    p_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);
endmodule

bind addr_xlat_top addr_xlat_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .xlat_err(xlat_err), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid)
);

// File: tb/tb_addr_xlat_top.sv
`timescale 1ns/1ps
module tb_addr_xlat_top;
    localparam int          N   = 8;
    localparam int          PB  = 12;
    localparam logic [31:0] WIN = 32'h4000_0000;
    localparam int          AW  = $clog2(N) + 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, out_valid, out_ready, xlat_err;
    logic [31:0]   req_addr;
    logic [63:0]   out_addr;
    logic          reg_wr, reg_rd, reg_rvalid;
    logic [AW-1:0] reg_addr;
    logic [31:0]   reg_wdata, reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    logic [63:0] m_tab [N];
    logic        m_v   [N];

    always #5 clk = ~clk;

    addr_xlat_top #(.N_ENTRIES(N), .PAGE_BITS(PB), .WIN_BASE(WIN)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .xlat_err(xlat_err),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_hit(input logic [31:0] a);
        logic [32:0] rel;
        rel = {1'b0, a} - {1'b0, WIN};
        if (rel[32] || rel[31:0] >= 32'(N << PB)) return 1'b0;
        return m_v[rel[31:PB] % N];
    endfunction

    function automatic logic [63:0] exp_host(input logic [31:0] a);
        logic [31:0] rel;
        rel = a - WIN;
        return {m_tab[rel[31:PB] % N][63:PB], a[PB-1:0]};
    endfunction

    function automatic logic [31:0] exp_word(input int wa);
        if (wa % 2 == 1) return m_tab[wa / 2][63:32];
        return m_tab[wa / 2][31:0] | {31'd0, m_v[wa / 2]};
    endfunction

    function automatic void model_write(input int wa, input logic [31:0] d);
        if (wa % 2 == 1) m_tab[wa / 2][63:32] = d;
        else begin
            m_tab[wa / 2][31:0] = d & 32'hFFFF_F000;
            m_v[wa / 2] = d[0];
        end
    endfunction

    task automatic reg_write(input int wa, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(wa); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(wa, d);
    endtask

    task automatic reg_read(input int wa, input string tag);
        logic [31:0] e;
        e = exp_word(wa);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = AW'(wa);
        @(negedge clk);
        reg_rd = 1'b0;
        check(reg_rvalid === 1'b1 && reg_rdata === e, tag, {32'd0, reg_rdata}, {32'd0, e});
        @(negedge clk);
        check(reg_rvalid === 1'b0, {tag, " rvalid drop"}, {63'd0, reg_rvalid}, 64'd0);
    endtask

    task automatic xlat_req(input logic [31:0] a, input string tag);
        bit          h;
        logic [63:0] e;
        h = exp_hit(a);
        e = exp_host(a);
        @(negedge clk);
        check(req_ready === 1'b1, {tag, " ready"}, {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (h) begin
            check(out_valid === 1'b1 && xlat_err === 1'b0 && out_addr === e, tag, out_addr, e);
        end else begin
            check(xlat_err === 1'b1 && out_valid === 1'b0, {tag, " miss"},
                  {62'd0, out_valid, xlat_err}, 64'd1);
            @(negedge clk);
            check(xlat_err === 1'b0, {tag, " err single pulse"}, {63'd0, xlat_err}, 64'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] e_a, e_b;
        void'($urandom(32'h1234_5678));
        for (int k = 0; k < N; k++) begin m_tab[k] = '0; m_v[k] = 1'b0; end
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; out_ready = 1'b1;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(out_valid === 1'b0 && xlat_err === 1'b0 && req_ready === 1'b1, "R1 outputs",
              {61'd0, out_valid, xlat_err, req_ready}, 64'd1);
        reg_read(0, "R1 low word zero");
        reg_read(2 * N - 1, "R1 high word zero");
        xlat_req(WIN, "R1 invalid after reset");

        // R2 / R3: directed entries, scattered host pages
        reg_write(0, 32'hDEAD_B001);
        reg_write(1, 32'h0000_0012);
        reg_write(2, 32'h1234_5001);
        reg_write(3, 32'h0000_ABCD);
        xlat_req(WIN + 32'h0000_0FFF, "R2 last byte page0");
        xlat_req(WIN + 32'h0000_1000, "R2 first byte page1");
        reg_write(4, 32'h5555_5FFF);
        reg_read(4, "R3 low bits discarded");
        reg_write(5, 32'h8000_0001);
        reg_read(5, "R3 high word");
        reg_write(5, 32'h0000_0077);
        reg_read(4, "R3 high write keeps valid");
        xlat_req(WIN + 32'h0000_2ABC, "R2 page2");

        // R5: invalid entry
        reg_write(6, 32'h0BAD_0000);
        xlat_req(WIN + 32'h0000_3010, "R5 invalid entry");
        reg_read(6, "R3 valid cleared");

        // R6: outside the window on both sides
        xlat_req(WIN - 32'd1, "R6 below window");
        xlat_req(WIN + 32'(N << PB), "R6 above window");
        reg_write(2 * (N - 1), 32'hCAFE_0001);
        xlat_req(WIN + 32'(N << PB) - 32'd1, "R6 last in-window byte");

        // R8 / R9: stall, write during stall, then release
        @(negedge clk);
        e_a = exp_host(WIN + 32'h123);
        out_ready = 1'b0; req_valid = 1'b1; req_addr = WIN + 32'h123;
        @(negedge clk);
        check(out_valid === 1'b1 && out_addr === e_a, "R7 stalled result", out_addr, e_a);
        req_addr = WIN + 32'h456;
        reg_wr = 1'b1; reg_addr = AW'(1); reg_wdata = 32'h0000_0099;
        check(req_ready === 1'b0, "R8 ready low in stall", {63'd0, req_ready}, 64'd0);
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(1, 32'h0000_0099);
        check(out_valid === 1'b1 && out_addr === e_a, "R9 held output unchanged by write", out_addr, e_a);
        @(negedge clk);
        check(out_addr === e_a, "R8 stable after stall", out_addr, e_a);
        e_b = exp_host(WIN + 32'h456);
        out_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(out_valid === 1'b1 && out_addr === e_b, "R9 new value after write", out_addr, e_b);
        @(negedge clk);
        check(out_valid === 1'b0, "R7 slot drains", {63'd0, out_valid}, 64'd0);

        // R9: write and request at the same edge
        e_a = exp_host(WIN + 32'h1234);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(3); reg_wdata = 32'h0000_4242;
        req_valid = 1'b1; req_addr = WIN + 32'h1234;
        @(negedge clk);
        reg_wr = 1'b0; req_valid = 1'b0;
        check(out_valid === 1'b1 && out_addr === e_a, "R9 same-edge uses old", out_addr, e_a);
        model_write(3, 32'h0000_4242);
        xlat_req(WIN + 32'h1234, "R9 next request uses new");

        // R2: random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0) begin
                reg_write(int'($urandom % (2 * N)), $urandom);
            end else if (op == 1) begin
                reg_read(int'($urandom % (2 * N)), "R3 random readback");
            end else begin
                xlat_req(WIN - 32'h100 + ($urandom % (32'(N << PB) + 32'h200)), "R2 random request");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule